// File: doc/BRIEF.md
# SPI Register Access Slave

This block is a four-wire SPI slave for a system-clocked design. It takes an active-low select, a serial clock, a serial data input and a serial data output. All three inputs are oversampled by the system clock through two-flop synchronizers, and the clock's rising edge is detected in the system domain.

Each transaction starts with a command byte. The command chooses one of four access classes: read a register, write a register, read the status byte, or hand off to the SRAM engine. The command also carries a register index. A bank of 64 sixteen-bit registers can be read and written. An external 8-bit status byte can be read but never written.

Register 0 is special: its low bits drive start, mode and data-rate control outputs. Two of the data-rate bits go on to a clock manager. SRAM-class commands are not executed here. The command byte is passed on with a one-cycle request pulse.

The master runs SPI mode 0. It shifts data on the falling edge and samples on the rising edge, most significant bit first. Each SCLK high and low phase must last at least 8 system-clock cycles.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset, spi_miso, sram_req, sram_cmd, ctl_start, ctl_mode, ctl_rate and clk_rate_sel are all 0.
- R2: SI is sampled on each SCLK rising edge, MSB first. Command bits 7..6 select the access class: 00 register read, 01 register write, 10 status read, 11 SRAM. Command bits 5..0 are the register index.
- R3: A register write takes the 16 bits after the command byte. These bits are stored at the indexed register once the 24th bit has been received, and a later read of that index returns them.
- R4: On a register read, the indexed register's 16 bits appear on SO MSB first. Bit 15 is valid before the 9th SCLK rising edge, and each following bit is valid before the next rising edge.
- R5: If select rises before all 24 bits of a write have been received, the write is discarded and the register keeps its old value.
- R6: A status read returns status_in, MSB first, in the first 8 data slots, followed by 8 zero bits. Data shifted in during a status access changes neither the register bank nor the status.
- R7: ctl_start is register 0 bit 0, ctl_mode is bit 1, and ctl_rate is bits 4..2. These outputs change only after a write to register 0.
- R8: clk_rate_sel equals ctl_rate bits 2..1, which are register 0 bits 4..3.
- R9: An SRAM-class command raises sram_req for exactly one system cycle, with sram_cmd holding the command byte. It does not write the register bank.
- R10: While select is high, SO is 0.
- R11: SCLK edges after the 24th bit of a transaction are ignored, so a write commits only once per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| status_in | input | 8 | Read-only status byte |
| ctl_start | output | 1 | Start flag, register 0 bit 0 |
| ctl_mode | output | 1 | Mode flag, register 0 bit 1 |
| ctl_rate | output | 3 | Data-rate select, register 0 bits 4..2 |
| clk_rate_sel | output | 2 | Data-rate bits 2..1 sent to the clock manager |
| sram_req | output | 1 | One-cycle pulse for an SRAM-class command |
| sram_cmd | output | 8 | Command byte for the SRAM engine |

## Verification
A wrong bit counter or a wrong command latch shows up at the ports within one transaction. It appears either as a wrong word read back on SO or as a register that takes a write it should have dropped; partial frames and frames with extra clocks are aimed at exactly this. A control field that drifts away from register 0 is visible on the control outputs in the cycle after the commit. Every register index is written and then read back, so a wrong address decode or a wrong bit order shows up on SO in the first read that crosses the wrong entry.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  typedef enum logic [1:0] {
    ACC_REG_RD = 2'b00,
    ACC_REG_WR = 2'b01,
    ACC_STATUS = 2'b10,
    ACC_SRAM   = 2'b11
  } acc_e;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sclk_rise,
  input  logic              mosi,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [STAT_W-1:0] status,
  output logic              cmd_done,
  output logic [CMD_W-1:0]  cmd,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso
);
  localparam int FRAME_BITS = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic              load_q;
  acc_e              cls;

  assign cls = acc_e'(cmd[CMD_W-1 -: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      load_q   <= 1'b0;
      cmd      <= '0;
      cmd_done <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      miso     <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      wr_en    <= 1'b0;
      load_q   <= cmd_done;
      if (sel_n) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
      end else if (sclk_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sr   <= {rx_sr[DATA_W-2:0], mosi};
        if (bit_cnt == CNT_W'(CMD_W - 1)) begin
          cmd      <= {rx_sr[CMD_W-2:0], mosi};
          cmd_done <= 1'b1;
        end
        if (bit_cnt == CNT_W'(FRAME_BITS - 1) && cls == ACC_REG_WR) begin
          wr_en   <= 1'b1;
          wr_data <= {rx_sr[DATA_W-2:0], mosi};
        end
        if (bit_cnt >= CNT_W'(CMD_W)) tx_sr <= tx_sr << 1;
      end
      if (load_q && !sel_n) begin
        case (cls)
          ACC_REG_RD: tx_sr <= rd_data;
          ACC_STATUS: tx_sr <= {status, {(DATA_W-STAT_W){1'b0}}};
          default:    tx_sr <= '0;
        endcase
      end
      miso <= !sel_n && tx_sr[DATA_W-1];
    end
  end
endmodule

// File: rtl/spi_rf_bank.sv
module spi_rf_bank #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int CTL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTL_W-1:0]  ctl
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] reg0;
  logic              rd_zero_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg0      <= '0;
      rd_zero_q <= 1'b0;
    end else begin
      if (wr_en && wr_idx == '0) reg0 <= wr_data;
      if (rd_en) rd_zero_q <= (rd_idx == '0);
    end
  end

  assign rd_data = rd_zero_q ? reg0 : mem_q;
  assign ctl     = reg0[CTL_W-1:0];
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int IDX_W       = 6,
  parameter int STAT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sel_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [STAT_W-1:0] status_in,
  output logic              ctl_start,
  output logic              ctl_mode,
  output logic [2:0]        ctl_rate,
  output logic [1:0]        clk_rate_sel,
  output logic              sram_req,
  output logic [IDX_W+1:0]  sram_cmd
);
  localparam int CMD_W = IDX_W + 2;
  localparam int CTL_W = 5;

  logic              sel_n_s, sclk_s, mosi_s, sclk_d, sclk_rise;
  logic              cmd_done, wr_en;
  logic [CMD_W-1:0]  cmd;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [CTL_W-1:0]  ctl;

  spi_rf_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({spi_sel_n, spi_sclk, spi_mosi}),
    .sync_out({sel_n_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end
  assign sclk_rise = sclk_s && !sclk_d;

  spi_rf_frame #(.CMD_W(CMD_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_frame (
    .clk(clk), .rst(rst), .sel_n(sel_n_s), .sclk_rise(sclk_rise), .mosi(mosi_s),
    .rd_data(rd_data), .status(status_in), .cmd_done(cmd_done), .cmd(cmd),
    .wr_en(wr_en), .wr_data(wr_data), .miso(spi_miso)
  );

  assign wr_idx = cmd[IDX_W-1:0];

  spi_rf_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CTL_W(CTL_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(cmd_done), .rd_idx(cmd[IDX_W-1:0]), .rd_data(rd_data), .ctl(ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_req <= 1'b0;
      sram_cmd <= '0;
    end else begin
      sram_req <= cmd_done && (acc_e'(cmd[CMD_W-1 -: 2]) == ACC_SRAM);
      if (cmd_done && acc_e'(cmd[CMD_W-1 -: 2]) == ACC_SRAM) sram_cmd <= cmd;
    end
  end

  assign ctl_start    = ctl[0];
  assign ctl_mode     = ctl[1];
  assign ctl_rate     = ctl[4:2];
  assign clk_rate_sel = ctl[4:3];
endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n_s,
  input logic             miso,
  input logic             sram_req,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [4:0]       ctl
);
  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !miso);

  assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == '0) |=> $stable(ctl));

  assert_sram_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    sram_req |=> !sram_req);

  assert_sram_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    sram_req |-> !wr_en);

  assert_single_commit_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

bind spi_regfile_slave spi_regfile_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .sel_n_s(sel_n_s), .miso(spi_miso),
  .sram_req(sram_req), .wr_en(wr_en), .wr_idx(wr_idx),
  .ctl({ctl_rate, ctl_mode, ctl_start})
);

// File: tb/spi_regfile_slave_tb.sv
module spi_regfile_slave_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic       miso;
  logic [7:0] status_in = 8'h00;
  logic       ctl_start, ctl_mode, sram_req;
  logic [2:0] ctl_rate;
  logic [1:0] clk_rate_sel;
  logic [7:0] sram_cmd;
  int         n_run = 0, n_fail = 0, sram_pulses = 0;

  always #2 clk = ~clk;

  spi_regfile_slave u_dut (
    .clk(clk), .rst(rst), .spi_sel_n(sel_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .status_in(status_in), .ctl_start(ctl_start),
    .ctl_mode(ctl_mode), .ctl_rate(ctl_rate), .clk_rate_sel(clk_rate_sel),
    .sram_req(sram_req), .sram_cmd(sram_cmd)
  );

  always @(posedge clk) if (!rst && sram_req) sram_pulses++;

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] frame, input int nbits, output logic [15:0] rd);
    rd = '0;
    sel_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = frame[31-i];
      wait_clk(HALF);
      if (i >= 8 && i < 24) rd = {rd[14:0], miso};
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    sel_n = 1'b1;
    wait_clk(12);
  endtask

  function automatic logic [15:0] pat(input int idx);
    return 16'((idx * 16'h0409) ^ 16'h5AC3);
  endfunction

  initial begin
    logic [15:0] rd;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    chk("R1 miso", miso, 0);
    chk("R1 sram_req", sram_req, 0);
    chk("R1 sram_cmd", sram_cmd, 0);
    chk("R1 ctl", {ctl_start, ctl_mode, ctl_rate, clk_rate_sel}, 0);

    // R2/R3: write every index (command 01_iiiiii)
    for (int i = 0; i < 64; i++) xfer({8'h40 | 8'(i), pat(i), 8'h00}, 24, rd);
    // R2/R4: read every index back (command 00_iiiiii)
    for (int i = 0; i < 64; i++) begin
      xfer({8'(i), 16'h0000, 8'h00}, 24, rd);
      chk($sformatf("R3 R4 readback idx=%0d", i), rd, pat(i));
    end
    chk("R10 miso idle after reads", miso, 0);

    // R7/R8: every register 0 control value
    for (int v = 0; v < 32; v++) begin
      xfer({8'h40, 16'(v), 8'h00}, 24, rd);
      chk($sformatf("R7 start v=%0d", v), ctl_start, v & 1);
      chk($sformatf("R7 mode v=%0d", v), ctl_mode, (v >> 1) & 1);
      chk($sformatf("R7 rate v=%0d", v), ctl_rate, (v >> 2) & 7);
      chk($sformatf("R8 clk_rate_sel v=%0d", v), clk_rate_sel, (v >> 3) & 3);
    end

    // R5: partial write of idx 5 discarded
    xfer({8'h45, 16'hFFFF, 8'h00}, 20, rd);
    xfer({8'h05, 16'h0000, 8'h00}, 24, rd);
    chk("R5 partial write discarded", rd, pat(5));

    // R11: extra clocks after 24 bits ignored
    xfer({8'h46, 16'hBEEF, 8'hFF}, 32, rd);
    xfer({8'h06, 16'h0000, 8'h00}, 24, rd);
    chk("R11 extra bits ignored", rd, 16'hBEEF);

    // R6: status read (command 10_xxxxxx), data in ignored
    status_in = 8'h5A;
    xfer({8'h85, 16'hFFFF, 8'h00}, 24, rd);
    chk("R6 status read 5A", rd, 16'h5A00);
    status_in = 8'hC3;
    xfer({8'h80, 16'h0000, 8'h00}, 24, rd);
    chk("R6 status read C3", rd, 16'hC300);
    xfer({8'h05, 16'h0000, 8'h00}, 24, rd);
    chk("R6 bank unchanged by status access", rd, pat(5));

    // R9: SRAM command hand-off (command 11_xxxxxx)
    xfer({8'hC7, 16'h1234, 8'h00}, 24, rd);
    chk("R9 sram pulse count", sram_pulses, 1);
    chk("R9 sram_cmd", sram_cmd, 8'hC7);
    xfer({8'h07, 16'h0000, 8'h00}, 24, rd);
    chk("R9 bank unchanged by sram cmd", rd, pat(7));
    chk("R10 miso idle at end", miso, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule